// File: doc/BRIEF.md
# I2C Register-Access Target

This block is a byte-oriented I2C target that gives an external bus controller access to a bank of 8-bit registers. It works in one system clock domain from SCL and SDA levels that have already been filtered and oversampled. It finds START, repeated START and STOP conditions and checks the 7-bit device address. It then runs one of two flows: a write, where the first byte loads a register pointer and any later bytes are stored, or a read, where bytes are shifted out starting at the current pointer. SDA is driven as an open-drain pull-down enable, and the block never holds SCL low.

The register bank connects through a plain port. The pointer goes out as the register address, and the bank sends back the read data and a flag that says whether that address is mapped. The block uses the flag to decide, byte by byte, whether to acknowledge. A pointer on an unmapped location still advances and wraps, so a burst can cross a hole in the map. Bytes written into the hole are refused, and bytes read from it come back as zero.

Top module: `i2c_reg_target`

## Requirements
- R1: The device address is the 7-bit value 101011s, where s is `addr_sel`, so it is 56h when `addr_sel` is low and 57h when it is high. The R/W bit is the LSB of the address byte (0 = write, 1 = read). A matching address byte is ACKed. Any other address byte is NACKed, and the block then ignores all bus traffic until the next START, without moving the pointer.
- R2: In a write transfer, the byte after the address byte loads the register pointer. It is ACKed when `reg_valid` is high for the new pointer value and NACKed when it is low. The pointer is not advanced after this byte.
- R3: Each later data byte in a write is sent to the bank through `reg_wdata`/`reg_we` and ACKed when the pointer is mapped. When the pointer is unmapped the byte is NACKed and no write strobe is issued.
- R4: `reg_we` is a single-cycle pulse and is only ever high while `reg_valid` is high.
- R5: The pointer advances by one after every data byte, whether written or read and whether mapped or not. It wraps from FFh to 00h.
- R6: The pointer is 00h after reset. A read transfer starts at the current pointer value, which is the last value loaded or reached if no pointer byte came first.
- R7: A read from an unmapped pointer puts 00h on the bus, whatever the bank returns.
- R8: When the controller NACKs a read byte, the target releases SDA and stays released on every later clock until a START or STOP. A STOP from any state returns the block to idle.
- R9: Bytes move MSB first, with a ninth clock for the acknowledge. The SDA enable changes only while SCL is low, one system clock after the falling SCL edge is detected.
- R10: A repeated START begins a new address phase at once. This allows a pointer write followed by a read, and it can cut off a write burst.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Filtered SCL level |
| sda_i | input | 1 | Filtered SDA level |
| addr_sel | input | 1 | Selects the LSB of the device address |
| sda_oe | output | 1 | Open-drain enable, 1 pulls SDA low |
| reg_addr | output | 8 | Register pointer presented to the bank |
| reg_wdata | output | 8 | Write data to the bank |
| reg_we | output | 1 | Single-cycle write strobe |
| reg_rdata | input | 8 | Read data from the bank at `reg_addr` |
| reg_valid | input | 1 | High when `reg_addr` is a mapped register |

## Verification
Some rules hold on every cycle and are checked by assertions:
- The SDA enable moves only while SCL is low.
- The enable is released in idle and in the controller's acknowledge slot.
- The write strobe is a lone pulse that only occurs at a mapped address.
- The pointer moves only on an SCL-low step or a pointer load.

Other behaviour only the bench scenarios can show: the address match over all 128 addresses for both select values, the ACK pattern over all 256 pointer values, and burst increments that wrap or cross unmapped holes. The same applies to zero data from holes, the pointer kept between transfers, and the silent bus after a controller NACK.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;
  localparam int BYTE_W = 8;
  localparam int BIT_CNT_W = 4;
  localparam logic [5:0] DEV_ADDR_BASE = 6'b101011;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_DEV,
    ST_DEV_ACK,
    ST_PTR,
    ST_PTR_ACK,
    ST_WR,
    ST_WR_ACK,
    ST_RD,
    ST_RD_ACK
  } tgt_state_e;

  // Address byte carries the 7-bit device address in bits 7:1.
  function automatic logic dev_match(input logic [BYTE_W-1:0] b, input logic sel);
    return b[BYTE_W-1:1] == {DEV_ADDR_BASE, sel};
  endfunction

  // Unmapped locations read as zero.
  function automatic logic [BYTE_W-1:0] rd_gate(input logic ok, input logic [BYTE_W-1:0] d);
    return ok ? d : '0;
  endfunction
endpackage

// File: rtl/i2c_line_mon.sv
module i2c_line_mon (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_lvl,
  output logic sda_lvl,
  output logic scl_rise,
  output logic scl_fall,
  output logic bus_start,
  output logic bus_stop
);
  logic scl_q, scl_p, sda_q, sda_p;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      scl_p <= 1'b1;
      sda_q <= 1'b1;
      sda_p <= 1'b1;
    end else begin
      scl_q <= scl_i;
      scl_p <= scl_q;
      sda_q <= sda_i;
      sda_p <= sda_q;
    end
  end

  assign scl_lvl   = scl_q;
  assign sda_lvl   = sda_q;
  assign scl_rise  = scl_q & ~scl_p;
  assign scl_fall  = ~scl_q & scl_p;
  assign bus_start = scl_q & scl_p & sda_p & ~sda_q;
  assign bus_stop  = scl_q & scl_p & ~sda_p & sda_q;
endmodule

// File: rtl/i2c_ptr_unit.sv
module i2c_ptr_unit #(
  parameter int PTR_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [PTR_W-1:0] load_val,
  input  logic             step,
  output logic [PTR_W-1:0] ptr
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    ptr <= '0;
    else if (load) ptr <= load_val;
    else if (step) ptr <= ptr + 1'b1;
  end
endmodule

// File: rtl/i2c_reg_target.sv
module i2c_reg_target
  import i2c_tgt_pkg::*;
#(
  parameter int PTR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic              addr_sel,
  output logic              sda_oe,
  output logic [PTR_W-1:0]  reg_addr,
  output logic [BYTE_W-1:0] reg_wdata,
  output logic              reg_we,
  input  logic [BYTE_W-1:0] reg_rdata,
  input  logic              reg_valid
);
  localparam logic [BIT_CNT_W-1:0] LAST_BIT = BIT_CNT_W'(BYTE_W - 1);
  localparam logic [BIT_CNT_W-1:0] FULL_CNT = BIT_CNT_W'(BYTE_W);

  logic scl_lvl, sda_lvl, scl_rise, scl_fall, bus_start, bus_stop;

  i2c_line_mon i_line (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_lvl(scl_lvl), .sda_lvl(sda_lvl), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .bus_start(bus_start), .bus_stop(bus_stop)
  );

  tgt_state_e           st;
  logic [BYTE_W-1:0]    shreg, txq, rx_now, rd_now;
  logic [BIT_CNT_W-1:0] bitcnt;
  logic                 rw_q, mack_q, byte_full;
  logic                 ptr_load, ptr_step;

  assign byte_full = (bitcnt == FULL_CNT);
  assign rx_now    = {shreg[BYTE_W-2:0], sda_lvl};
  assign rd_now    = rd_gate(reg_valid, reg_rdata);
  assign ptr_load  = (st == ST_PTR) && scl_rise && (bitcnt == LAST_BIT);
  assign ptr_step  = scl_fall && ((st == ST_WR_ACK) || (st == ST_RD && byte_full));

  i2c_ptr_unit #(.PTR_W(PTR_W)) i_ptr (
    .clk(clk), .rst_n(rst_n), .load(ptr_load), .load_val(PTR_W'(rx_now)),
    .step(ptr_step), .ptr(reg_addr)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      sda_oe    <= 1'b0;
      bitcnt    <= '0;
      shreg     <= '0;
      txq       <= '0;
      rw_q      <= 1'b0;
      mack_q    <= 1'b0;
      reg_we    <= 1'b0;
      reg_wdata <= '0;
    end else begin
      reg_we <= 1'b0;
      if (bus_stop) begin
        st     <= ST_IDLE;
        sda_oe <= 1'b0;
      end else if (bus_start) begin
        st     <= ST_DEV;
        sda_oe <= 1'b0;
        bitcnt <= '0;
      end else begin
        case (st)
          ST_DEV, ST_PTR, ST_WR: begin
            if (scl_rise && !byte_full) begin
              shreg  <= rx_now;
              bitcnt <= bitcnt + 1'b1;
            end else if (scl_fall && byte_full) begin
              bitcnt <= '0;
              if (st == ST_DEV) begin
                if (dev_match(shreg, addr_sel)) begin
                  sda_oe <= 1'b1;
                  rw_q   <= shreg[0];
                  st     <= ST_DEV_ACK;
                end else begin
                  st <= ST_IDLE;
                end
              end else if (st == ST_PTR) begin
                sda_oe <= reg_valid;
                st     <= ST_PTR_ACK;
              end else begin
                sda_oe    <= reg_valid;
                reg_we    <= reg_valid;
                reg_wdata <= shreg;
                st        <= ST_WR_ACK;
              end
            end
          end
          ST_DEV_ACK: if (scl_fall) begin
            bitcnt <= '0;
            if (rw_q) begin
              txq    <= rd_now;
              sda_oe <= ~rd_now[BYTE_W-1];
              st     <= ST_RD;
            end else begin
              sda_oe <= 1'b0;
              st     <= ST_PTR;
            end
          end
          ST_PTR_ACK, ST_WR_ACK: if (scl_fall) begin
            sda_oe <= 1'b0;
            bitcnt <= '0;
            st     <= ST_WR;
          end
          ST_RD: begin
            if (scl_rise && !byte_full) begin
              bitcnt <= bitcnt + 1'b1;
            end else if (scl_fall) begin
              if (byte_full) begin
                sda_oe <= 1'b0;
                bitcnt <= '0;
                st     <= ST_RD_ACK;
              end else begin
                txq    <= txq << 1;
                sda_oe <= ~txq[BYTE_W-2];
              end
            end
          end
          ST_RD_ACK: begin
            if (scl_rise) begin
              mack_q <= ~sda_lvl;
            end else if (scl_fall) begin
              if (mack_q) begin
                txq    <= rd_now;
                sda_oe <= ~rd_now[BYTE_W-1];
                st     <= ST_RD;
              end else begin
                st <= ST_IDLE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  // SDA enable only moves while SCL is low (R9)
  assert_oe_scl_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !$past(scl_lvl));

  // Idle target never pulls SDA (R1)
  assert_idle_release_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_IDLE) |-> !sda_oe);

  // Controller acknowledge slot left free (R8)
  assert_rd_ack_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_RD_ACK) |-> !sda_oe);

  // Write strobe only at a mapped location (R3)
  assert_we_mapped_R3: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |-> reg_valid);

  // Write strobe is a lone pulse (R4)
  assert_we_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |=> !reg_we);

  // Pointer moves only on an SCL-low step or a pointer load (R5)
  assert_ptr_moves_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr != $past(reg_addr)) |-> (!$past(scl_lvl) || $past(st) == ST_PTR));
endmodule

// File: tb/test_i2c_reg_target.sv
module test_i2c_reg_target;
  localparam int CLK_PERIOD = 10;
  localparam int QTR = 4;

  logic clk = 1'b0, rst_n = 1'b0, scl_m = 1'b1, sda_m = 1'b1, addr_sel = 1'b0;
  logic sda_oe, reg_we, reg_valid;
  logic [7:0] reg_addr, reg_wdata, reg_rdata;
  wire sda_line = sda_m & ~sda_oe;

  logic [7:0] bank [256];
  logic [7:0] expv [256];
  int n_chk = 0, n_fail = 0, n_we = 0;
  bit oe_high_change = 0, we_bad = 0;
  logic scl_d = 1'b1, oe_d = 1'b0, we_d = 1'b0;

  function automatic bit mapped(input logic [7:0] a);
    return (a <= 8'h05) || (a >= 8'hFE);
  endfunction

  assign reg_valid = mapped(reg_addr);
  assign reg_rdata = bank[reg_addr];

  i2c_reg_target i_i2c_reg_target (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line), .addr_sel(addr_sel),
    .sda_oe(sda_oe), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_we(reg_we),
    .reg_rdata(reg_rdata), .reg_valid(reg_valid)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    if (reg_we) begin
      bank[reg_addr] <= reg_wdata;
      n_we = n_we + 1;
      if (!reg_valid || we_d) we_bad = 1;
    end
    if (rst_n && scl_m && scl_d && (sda_oe !== oe_d)) oe_high_change = 1;
    scl_d <= scl_m;
    oe_d  <= sda_oe;
    we_d  <= reg_we;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic waitq();
    repeat (QTR) @(posedge clk);
    #2;
  endtask

  task automatic clock_bit(input logic d, output logic s);
    sda_m = d; waitq();
    scl_m = 1'b1; waitq();
    s = sda_line; waitq();
    scl_m = 1'b0; waitq();
  endtask

  task automatic bus_start();
    sda_m = 1'b1; waitq();
    scl_m = 1'b1; waitq();
    sda_m = 1'b0; waitq();
    scl_m = 1'b0; waitq();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; waitq();
    scl_m = 1'b1; waitq();
    sda_m = 1'b1; waitq();
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    logic s;
    for (int i = 7; i >= 0; i--) clock_bit(b[i], s);
    clock_bit(1'b1, s);
    ack = ~s;
  endtask

  task automatic recv_byte(input logic give_ack, output logic [7:0] b);
    logic s;
    b = '0;
    for (int i = 0; i < 8; i++) begin
      clock_bit(1'b1, s);
      b = {b[6:0], s};
    end
    clock_bit(~give_ack, s);
  endtask

  function automatic logic [7:0] dev_byte(input logic rd);
    return {6'b101011, addr_sel, rd};
  endfunction

  task automatic set_ptr(input logic [7:0] p, output logic ackp);
    logic a;
    bus_start();
    send_byte(dev_byte(1'b0), a);
    send_byte(p, ackp);
  endtask

  task automatic write_seq(input string req, input logic [7:0] d);
    logic a;
    logic [7:0] p;
    p = reg_addr;
    send_byte(d, a);
    check(req, a, mapped(p));
    if (mapped(p)) expv[p] = d;
  endtask

  task automatic read_seq(input string req, input logic give_ack);
    logic [7:0] d, p;
    p = reg_addr;
    recv_byte(give_ack, d);
    check(req, d, mapped(p) ? expv[p] : 8'h00);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic a, s;
    logic [7:0] d;
    int we0;
    for (int i = 0; i < 256; i++) begin
      bank[i] = 8'((i * 7) + 3);
      expv[i] = bank[i];
    end
    repeat (5) @(posedge clk);
    #2 rst_n = 1'b1;
    waitq();
    check("R6 reset sda_oe", sda_oe, 0);
    check("R4 reset reg_we", reg_we, 0);
    check("R6 reset pointer", reg_addr, 8'h00);

    // R1: every address for both select values
    for (int sel = 0; sel < 2; sel++) begin
      addr_sel = sel[0];
      for (int ad = 0; ad < 128; ad++) begin
        bus_start();
        send_byte({ad[6:0], 1'b0}, a);
        bus_stop();
        check("R1 address match", a, (ad[6:0] == {6'b101011, sel[0]}));
      end
    end
    // R1: after a mismatch the target ignores the rest of the transfer
    addr_sel = 1'b0;
    bus_start();
    send_byte(8'hAE, a);
    check("R1 mismatch nack", a, 0);
    send_byte(8'h00, a);
    check("R1 idle after mismatch", a, 0);
    bus_stop();
    check("R1 pointer untouched", reg_addr, 8'h00);

    // R2: every pointer value
    for (int p = 0; p < 256; p++) begin
      set_ptr(p[7:0], a);
      bus_stop();
      check("R2 pointer ack", a, mapped(p[7:0]));
      check("R2 pointer loaded", reg_addr, p[7:0]);
    end

    // R6: read with no pointer byte continues at FFh, then wraps (R5)
    bus_start();
    send_byte(dev_byte(1'b1), a);
    read_seq("R6 read current pointer", 1'b0);
    bus_stop();
    check("R5 wrap after read", reg_addr, 8'h00);

    // R3: write burst running into a hole
    we0 = n_we;
    set_ptr(8'h03, a);
    for (int i = 0; i < 4; i++) write_seq("R3 burst ack", 8'hA0 + 8'(i));
    bus_stop();
    check("R3 strobes in burst", n_we - we0, 3);
    check("R5 pointer after burst", reg_addr, 8'h07);

    // R3/R5: start in a hole, reach mapped space, wrap to 00h
    we0 = n_we;
    set_ptr(8'hFD, a);
    check("R2 unmapped pointer nack", a, 0);
    for (int i = 0; i < 4; i++) write_seq("R3 hole then mapped", 8'h60 + 8'(i));
    bus_stop();
    check("R3 strobes across wrap", n_we - we0, 3);
    check("R5 wrap after write", reg_addr, 8'h01);

    // R10: pointer write, repeated START, sequential read across wrap
    set_ptr(8'hFE, a);
    bus_start();
    send_byte(dev_byte(1'b1), a);
    check("R10 read address ack", a, 1);
    for (int i = 0; i < 4; i++) read_seq("R10 sequential read", i < 3);
    bus_stop();
    check("R5 pointer after read burst", reg_addr, 8'h02);

    // R7: unmapped read returns zero
    set_ptr(8'h10, a);
    bus_start();
    send_byte(dev_byte(1'b1), a);
    for (int i = 0; i < 2; i++) read_seq("R7 unmapped read", i == 0);
    bus_stop();
    check("R5 pointer after hole read", reg_addr, 8'h12);

    // R8: after a controller NACK the bus stays released
    set_ptr(8'h00, a);
    bus_start();
    send_byte(dev_byte(1'b1), a);
    read_seq("R8 last byte", 1'b0);
    for (int i = 0; i < 9; i++) begin
      clock_bit(1'b1, s);
      check("R8 released after nack", s, 1);
    end
    bus_stop();
    check("R8 no further step", reg_addr, 8'h01);

    // R10: repeated START cuts a write burst
    set_ptr(8'h02, a);
    write_seq("R10 write before restart", 8'h5A);
    bus_start();
    send_byte(dev_byte(1'b1), a);
    read_seq("R10 read after restart", 1'b0);
    bus_stop();
    set_ptr(8'h02, a);
    bus_start();
    send_byte(dev_byte(1'b1), a);
    recv_byte(1'b0, d);
    bus_stop();
    check("R3 stored value read back", d, 8'h5A);

    // R1: second select value drives a full write/read
    addr_sel = 1'b1;
    set_ptr(8'h04, a);
    write_seq("R1 select high write", 8'h3C);
    bus_stop();
    set_ptr(8'h04, a);
    bus_start();
    send_byte(dev_byte(1'b1), a);
    read_seq("R1 select high read", 1'b0);
    bus_stop();

    check("R4 strobe pulse and mapping", we_bad, 0);
    check("R9 sda enable stable while SCL high", oe_high_change, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule